// File: doc/BRIEF.md
# Bypass Source Location Scoreboard

This block tracks, for every physical register tag of an out-of-order core, where that tag's value can be picked up. The value may be on a given execution lane's bypass network at a given level. It may be in the register file. Or it may not exist yet. When a producer is scheduled on issue lane i, it writes its tag with the number of cycles until its result leaves the functional unit. From then on the entry moves forward by itself each cycle. The value appears on bypass level 0 of lane i, then moves down through the deeper levels that cover the register-file write latency. After that the entry reports the register file.

A writeback-completion port can also mark a tag as resident in the register file at any time. In the operand-read stage, every source operand looks up its tag. It gets back an encoded select for the operand bypass muxes: register file, bypass lane and level, or "not yet produced". Schedule and writeback updates made in a cycle are already visible to lookups in that same cycle. This means a consumer never depends on the order of table writes and reads.

With the default parameters there are 64 tags, 4 lanes (4 schedule ports, 4 writeback ports and 8 lookup ports), a 3-level bypass and a 3-bit countdown per entry.

Top module: `bypass_loc_sb`

## Requirements
- R1: After reset, every tag reports register-file residence: rdSrcRf=1, rdWait=0, rdLane=0, rdLevel=0.
- R2: A schedule on port i in cycle t with latency L (0..5) makes lookups of that tag report the following: rdWait=1 in cycles t..t+L-1; lane i at level k in cycle t+L+k for k=0..2; register file from cycle t+L+3 onward.
- R3: A schedule latency above 5 behaves exactly like latency 5.
- R4: A writeback on any retire port makes the tag report the register file from that cycle on, whatever countdown it had.
- R5: A schedule or writeback made in a cycle is already reflected in lookups of the same tag in that same cycle.
- R6: If a tag is both scheduled and written back in the same cycle, the schedule takes effect and the writeback is dropped.
- R7: If several schedule ports write the same tag in one cycle, the lowest-numbered port wins, and its port number becomes the recorded lane.
- R8: Select encoding: register file gives rdSrcRf=1 and rdWait=0. "Not yet produced" gives rdWait=1 and rdSrcRf=0. In both of these cases rdLane=0 and rdLevel=0. A bypass hit gives both flags 0, with rdLane set to the lane and rdLevel set to the level (0 nearest the unit, 2 deepest).
- R9: Updates to one tag leave every other tag's entry unchanged, apart from its own countdown.
- R10: All 8 lookup ports work independently and may name any tag, including the same tag more than once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrValid | input | 4 | Schedule strobe per issue lane |
| wrTag | input | 24 | Destination tag per schedule port, 6 bits each, port 0 in the low bits |
| wrLat | input | 12 | Cycles until result per schedule port, 3 bits each |
| retValid | input | 4 | Writeback-complete strobe per port |
| retTag | input | 24 | Tag per writeback port, 6 bits each |
| rdTag | input | 48 | Source tag per lookup port, 6 bits each |
| rdSrcRf | output | 8 | Per lookup: take operand from register file |
| rdWait | output | 8 | Per lookup: value not produced yet |
| rdLane | output | 16 | Per lookup: bypass lane, 2 bits each |
| rdLevel | output | 16 | Per lookup: bypass level, 2 bits each |

## Verification
The hardest states to reach are collisions on a single tag within one cycle. These include two schedule ports writing it, a schedule racing a writeback, and a lookup of a tag being written in that same cycle, all while older countdowns are still moving. Directed sequences set up each collision explicitly. The random phase then draws destination, writeback and source tags from a pool of only 16 to 20 tags, so overlaps happen every few cycles instead of almost never. Lookups are also sampled in every cycle of a countdown, which catches off-by-one level transitions.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  localparam int NUM_TAGS  = 64;
  localparam int NUM_LANES = 4;
  localparam int WB_DEPTH  = 3;
  localparam int CNT_W     = 3;
  localparam int NUM_RD    = 2 * NUM_LANES;
  localparam int TAG_W     = $clog2(NUM_TAGS);
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int LVL_W     = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;
  localparam int EXT_W     = CNT_W + 1;
  localparam int CNT_MAX   = (1 << CNT_W) - 1;
  localparam int LAT_MAX   = CNT_MAX - WB_DEPTH + 1;

  // one table entry: cnt = cycles left before the value is in the register file
  typedef struct packed {
    logic              inRf;
    logic [LANE_W-1:0] lane;
    logic [CNT_W-1:0]  cnt;
  } entry_t;

  // per-tag update strobes from control to datapath
  typedef struct packed {
    logic              sched;
    logic [LANE_W-1:0] lane;
    logic [CNT_W-1:0]  cnt;
    logic              retire;
  } strobe_t;
endpackage

// File: rtl/bsb_ctrl.sv
module bsb_ctrl
  import bsb_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LANES-1:0]        wrValid,
  input  logic [NUM_LANES*TAG_W-1:0]  wrTag,
  input  logic [NUM_LANES*CNT_W-1:0]  wrLat,
  input  logic [NUM_LANES-1:0]        retValid,
  input  logic [NUM_LANES*TAG_W-1:0]  retTag,
  output strobe_t                     strobes [NUM_TAGS]
);

  function automatic logic [CNT_W-1:0] latToCnt(input logic [CNT_W-1:0] lat);
    logic [EXT_W-1:0] ext;
    ext = {1'b0, lat};
    if (ext > EXT_W'(LAT_MAX)) return CNT_W'(CNT_MAX);
    return CNT_W'(ext + EXT_W'(WB_DEPTH - 1));
  endfunction

  always_comb begin
    for (int t = 0; t < NUM_TAGS; t++) begin
      strobes[t] = '0;
      for (int p = NUM_LANES - 1; p >= 0; p--) begin
        if (retValid[p] && retTag[p*TAG_W +: TAG_W] == TAG_W'(t))
          strobes[t].retire = 1'b1;
      end
      // descending scan: the lowest matching port is assigned last and wins
      for (int p = NUM_LANES - 1; p >= 0; p--) begin
        if (wrValid[p] && wrTag[p*TAG_W +: TAG_W] == TAG_W'(t)) begin
          strobes[t].sched = 1'b1;
          strobes[t].lane  = LANE_W'(p);
          strobes[t].cnt   = latToCnt(wrLat[p*CNT_W +: CNT_W]);
        end
      end
    end
  end

  generate
    for (genvar gp = 1; gp < NUM_LANES; gp++) begin : g_prio
      // R7
      port0_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        (wrValid[0] && wrValid[gp] && wrTag[gp*TAG_W +: TAG_W] == wrTag[TAG_W-1:0])
        |-> (strobes[wrTag[TAG_W-1:0]].lane == '0));
    end
  endgenerate

  // R6
  sched_over_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid[0] && retValid[0] && wrTag[TAG_W-1:0] == retTag[TAG_W-1:0])
    |-> strobes[wrTag[TAG_W-1:0]].sched);

endmodule

// File: rtl/bsb_table.sv
module bsb_table
  import bsb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes [NUM_TAGS],
  output entry_t  eff     [NUM_TAGS]
);

  entry_t stored [NUM_TAGS];

  function automatic entry_t advance(input entry_t e);
    entry_t n;
    n = e;
    if (!e.inRf) begin
      if (e.cnt == '0) begin
        n.inRf = 1'b1;
        n.lane = '0;
      end else begin
        n.cnt = e.cnt - CNT_W'(1);
      end
    end
    return n;
  endfunction

  // effective view: this cycle's updates forwarded over the stored state
  always_comb begin
    for (int t = 0; t < NUM_TAGS; t++) begin
      eff[t] = stored[t];
      if (strobes[t].sched) begin
        eff[t].inRf = 1'b0;
        eff[t].lane = strobes[t].lane;
        eff[t].cnt  = strobes[t].cnt;
      end else if (strobes[t].retire) begin
        eff[t] = '{inRf: 1'b1, lane: '0, cnt: '0};
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NUM_TAGS; t++) begin
      if (!rstN) stored[t] <= '{inRf: 1'b1, lane: '0, cnt: '0};
      else       stored[t] <= advance(eff[t]);
    end
  end

  generate
    for (genvar gt = 0; gt < NUM_TAGS; gt++) begin : g_chk
      // R2
      countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!eff[gt].inRf && eff[gt].cnt != '0)
        |=> (!stored[gt].inRf && stored[gt].cnt == $past(eff[gt].cnt) - CNT_W'(1)));
      // R2
      expire_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!eff[gt].inRf && eff[gt].cnt == '0) |=> stored[gt].inRf);
      // R4
      retire_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobes[gt].retire && !strobes[gt].sched) |=> stored[gt].inRf);
    end
  endgenerate

endmodule

// File: rtl/bsb_rdport.sv
module bsb_rdport
  import bsb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  entry_t            ent,
  output logic              srcRf,
  output logic              isWait,
  output logic [LANE_W-1:0] lane,
  output logic [LVL_W-1:0]  level
);

  always_comb begin
    srcRf  = 1'b0;
    isWait = 1'b0;
    lane   = '0;
    level  = '0;
    if (ent.inRf) begin
      srcRf = 1'b1;
    end else if (ent.cnt >= CNT_W'(WB_DEPTH)) begin
      isWait = 1'b1;
    end else begin
      lane  = ent.lane;
      level = LVL_W'(WB_DEPTH - 1 - int'(ent.cnt));
    end
  end

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({srcRf, isWait}));
  // R8
  idle_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcRf || isWait) |-> (lane == '0 && level == '0));
  // R8
  level_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcRf && !isWait) |-> (int'(level) < WB_DEPTH));

endmodule

// File: rtl/bypass_loc_sb.sv
module bypass_loc_sb
  import bsb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_LANES-1:0]       wrValid,
  input  logic [NUM_LANES*TAG_W-1:0] wrTag,
  input  logic [NUM_LANES*CNT_W-1:0] wrLat,
  input  logic [NUM_LANES-1:0]       retValid,
  input  logic [NUM_LANES*TAG_W-1:0] retTag,
  input  logic [NUM_RD*TAG_W-1:0]    rdTag,
  output logic [NUM_RD-1:0]          rdSrcRf,
  output logic [NUM_RD-1:0]          rdWait,
  output logic [NUM_RD*LANE_W-1:0]   rdLane,
  output logic [NUM_RD*LVL_W-1:0]    rdLevel
);

  strobe_t strobes [NUM_TAGS];
  entry_t  eff     [NUM_TAGS];
  entry_t  rdEnt   [NUM_RD];

  bsb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrTag(wrTag), .wrLat(wrLat),
    .retValid(retValid), .retTag(retTag),
    .strobes(strobes)
  );

  bsb_table table_i (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .eff(eff)
  );

  always_comb begin
    for (int r = 0; r < NUM_RD; r++)
      rdEnt[r] = eff[rdTag[r*TAG_W +: TAG_W]];
  end

  generate
    for (genvar gr = 0; gr < NUM_RD; gr++) begin : g_rd
      bsb_rdport rdport_i (
        .clk(clk), .rstN(rstN),
        .ent(rdEnt[gr]),
        .srcRf(rdSrcRf[gr]),
        .isWait(rdWait[gr]),
        .lane(rdLane[gr*LANE_W +: LANE_W]),
        .level(rdLevel[gr*LVL_W +: LVL_W])
      );
      for (genvar gw = 0; gw < NUM_LANES; gw++) begin : g_fwd
        // R5
        fwd_sched_chk: assert property (@(posedge clk) disable iff (!rstN)
          (wrValid[gw] && wrTag[gw*TAG_W +: TAG_W] == rdTag[gr*TAG_W +: TAG_W])
          |-> !rdSrcRf[gr]);
      end
    end
  endgenerate

endmodule

// File: tb/bypass_loc_sb_tb.sv
module bypass_loc_sb_tb_top;
  import bsb_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_LANES-1:0]       wrValid, retValid;
  logic [NUM_LANES*TAG_W-1:0] wrTag, retTag;
  logic [NUM_LANES*CNT_W-1:0] wrLat;
  logic [NUM_RD*TAG_W-1:0]    rdTag;
  logic [NUM_RD-1:0]          rdSrcRf, rdWait;
  logic [NUM_RD*LANE_W-1:0]   rdLane;
  logic [NUM_RD*LVL_W-1:0]    rdLevel;

  int bWrValid [NUM_LANES], bWrTag [NUM_LANES], bWrLat [NUM_LANES];
  int bRetValid [NUM_LANES], bRetTag [NUM_LANES], bRdTag [NUM_RD];
  int mIn [NUM_TAGS], mLane [NUM_TAGS], mCnt [NUM_TAGS];
  int eIn [NUM_TAGS], eLane [NUM_TAGS], eCnt [NUM_TAGS];
  int checks = 0, failures = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  bypass_loc_sb dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrTag(wrTag), .wrLat(wrLat),
    .retValid(retValid), .retTag(retTag), .rdTag(rdTag),
    .rdSrcRf(rdSrcRf), .rdWait(rdWait), .rdLane(rdLane), .rdLevel(rdLevel)
  );

  always_comb begin
    for (int p = 0; p < NUM_LANES; p++) begin
      wrValid[p] = (bWrValid[p] != 0);
      wrTag[p*TAG_W +: TAG_W] = TAG_W'(bWrTag[p]);
      wrLat[p*CNT_W +: CNT_W] = CNT_W'(bWrLat[p]);
      retValid[p] = (bRetValid[p] != 0);
      retTag[p*TAG_W +: TAG_W] = TAG_W'(bRetTag[p]);
    end
    for (int r = 0; r < NUM_RD; r++) rdTag[r*TAG_W +: TAG_W] = TAG_W'(bRdTag[r]);
  end

  task automatic clearInputs();
    for (int p = 0; p < NUM_LANES; p++) begin
      bWrValid[p] = 0; bWrTag[p] = 0; bWrLat[p] = 0; bRetValid[p] = 0; bRetTag[p] = 0;
    end
  endtask

  task automatic readAll(input int tag);
    for (int r = 0; r < NUM_RD; r++) bRdTag[r] = tag;
  endtask

  // effective model view after this cycle's updates (requirements R4..R7)
  task automatic modelEffective();
    for (int t = 0; t < NUM_TAGS; t++) begin
      eIn[t] = mIn[t]; eLane[t] = mLane[t]; eCnt[t] = mCnt[t];
      for (int p = 0; p < NUM_LANES; p++)
        if (bRetValid[p] != 0 && bRetTag[p] == t) begin eIn[t] = 1; eLane[t] = 0; eCnt[t] = 0; end
      for (int p = 0; p < NUM_LANES; p++)
        if (bWrValid[p] != 0 && bWrTag[p] == t) begin
          eIn[t] = 0; eLane[t] = p;
          eCnt[t] = (bWrLat[p] > 5) ? 7 : bWrLat[p] + WB_DEPTH - 1;
          break;
        end
    end
  endtask

  task automatic checkReads();
    for (int r = 0; r < NUM_RD; r++) begin
      int t, xRf, xW, xL, xV, gRf, gW, gL, gV;
      t = bRdTag[r];
      xRf = 0; xW = 0; xL = 0; xV = 0;
      if (eIn[t] != 0) xRf = 1;
      else if (eCnt[t] >= WB_DEPTH) xW = 1;
      else begin xL = eLane[t]; xV = WB_DEPTH - 1 - eCnt[t]; end
      gRf = int'(rdSrcRf[r]); gW = int'(rdWait[r]);
      gL = int'(rdLane[r*LANE_W +: LANE_W]); gV = int'(rdLevel[r*LVL_W +: LVL_W]);
      checks++;
      if (gRf != xRf || gW != xW || gL != xL || gV != xV) begin
        failures++;
        $display("FAIL %s rd%0d tag%0d: got rf=%0d wait=%0d lane=%0d lvl=%0d exp rf=%0d wait=%0d lane=%0d lvl=%0d",
                 curReq, r, t, gRf, gW, gL, gV, xRf, xW, xL, xV);
      end
    end
  endtask

  // inputs set before the call (after a negedge); check, then take the edge
  task automatic stepCycle();
    modelEffective();
    #5;
    checkReads();
    @(posedge clk);
    for (int t = 0; t < NUM_TAGS; t++) begin
      mIn[t] = eIn[t]; mLane[t] = eLane[t]; mCnt[t] = eCnt[t];
      if (eIn[t] == 0) begin
        if (eCnt[t] == 0) begin mIn[t] = 1; mLane[t] = 0; end
        else mCnt[t] = eCnt[t] - 1;
      end
    end
    @(negedge clk);
    clearInputs();
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clearInputs();
    readAll(0);
    for (int t = 0; t < NUM_TAGS; t++) begin mIn[t] = 1; mLane[t] = 0; mCnt[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state on many tags
    curReq = "R1";
    for (int k = 0; k < 8; k++) begin
      for (int r = 0; r < NUM_RD; r++) bRdTag[r] = k * NUM_RD + r;
      stepCycle();
    end

    // R5 then R2: schedule tag 5 on lane 2, latency 1, follow every stage
    curReq = "R5";
    readAll(5); bWrValid[2] = 1; bWrTag[2] = 5; bWrLat[2] = 1;
    stepCycle();
    curReq = "R2";
    for (int k = 0; k < 6; k++) begin readAll(5); stepCycle(); end

    // R2 latency 0 on lane 3: level 0 in the write cycle
    curReq = "R2";
    readAll(6); bWrValid[3] = 1; bWrTag[3] = 6; bWrLat[3] = 0;
    stepCycle();
    for (int k = 0; k < 4; k++) begin readAll(6); stepCycle(); end

    // R3: latency 7 saturates to 5
    curReq = "R3";
    readAll(9); bWrValid[1] = 1; bWrTag[1] = 9; bWrLat[1] = 7;
    stepCycle();
    for (int k = 0; k < 9; k++) begin readAll(9); stepCycle(); end

    // R4: early writeback overrides countdown, visible same cycle
    curReq = "R4";
    readAll(12); bWrValid[0] = 1; bWrTag[0] = 12; bWrLat[0] = 4;
    stepCycle();
    readAll(12); bRetValid[3] = 1; bRetTag[3] = 12;
    stepCycle();
    for (int k = 0; k < 3; k++) begin readAll(12); stepCycle(); end

    // R6: schedule and writeback of the same tag together
    curReq = "R6";
    readAll(20); bWrValid[1] = 1; bWrTag[1] = 20; bWrLat[1] = 2;
    bRetValid[0] = 1; bRetTag[0] = 20;
    stepCycle();
    for (int k = 0; k < 5; k++) begin readAll(20); stepCycle(); end

    // R7: three ports schedule tag 33; port 1 is the lowest
    curReq = "R7";
    readAll(33);
    bWrValid[3] = 1; bWrTag[3] = 33; bWrLat[3] = 0;
    bWrValid[1] = 1; bWrTag[1] = 33; bWrLat[1] = 1;
    bWrValid[2] = 1; bWrTag[2] = 33; bWrLat[2] = 3;
    stepCycle();
    for (int k = 0; k < 5; k++) begin readAll(33); stepCycle(); end

    // R8 R9 R10: random traffic over a small tag pool
    curReq = "R8/R9/R10";
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < NUM_LANES; p++) begin
        bWrValid[p]  = ($urandom % 3 == 0) ? 1 : 0;
        bWrTag[p]    = $urandom % 16;
        bWrLat[p]    = $urandom % 8;
        bRetValid[p] = ($urandom % 5 == 0) ? 1 : 0;
        bRetTag[p]   = $urandom % 16;
      end
      for (int r = 0; r < NUM_RD; r++) bRdTag[r] = $urandom % 20;
      stepCycle();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule